// File: doc/BRIEF.md
# Interrupt Mask and Force Logic

This block gathers 64 asynchronous interrupt source lines, brings each one into the clock domain through a short synchronizer, and combines them into one interrupt request for a processor. Each source can be held off by a mask bit. Each source can also be raised by software through a force bit, and a forced request is never held off by the mask. The synchronized level of every source can be read back at any time, whatever its mask bit says.

Software reaches the block through a simple register port. A read strobe returns data in the same cycle, and a write strobe updates a register at the next clock edge. The 64 sources are split across pairs of 32-bit registers. The register that ends in "lo" covers sources 0 to 31, and the one that ends in "hi" covers sources 32 to 63. The per-source qualified request vector is also driven on a port, so a later priority stage can use it. The block has no state machine. Its only sequential state is the synchronizer pipeline and the mask and force registers.

Top module: `irqmf_top`

## Requirements
- R1: After reset, every mask bit reads 1, every force bit reads 0, and irq_o is 0.
- R2: Bit j of a "lo" register belongs to source j. Bit j of a "hi" register belongs to source 32+j.
- R3: When a source's force bit is 0, a mask bit of 1 keeps that source's request at 0, and a mask bit of 0 passes the synchronized source level to the request.
- R4: Writing 1 to a force bit makes that source's request 1 whatever its mask bit and source level are. Writing 0 to the force bit removes the forced request.
- R5: The pending view shows the synchronized source level even while the source is masked. It does not latch: it returns to 0 when the source returns to 0.
- R6: A change on src_i that is set up before clock edge n shows in the pending view and in the request after edge n+1, and not before.
- R7: Register offsets on addr_i are 0x00 pending hi, 0x04 pending lo, 0x08 mask hi, 0x0C mask lo, 0x10 force hi and 0x14 force lo. The pending registers are read-only.
- R8: A write to a pending offset, or to any offset not listed in R7, changes no mask bit and no force bit.
- R9: While rd_en_i is 1, rdata_o shows the addressed register in the same cycle. It shows 0 for an unlisted offset, and it shows 0 whenever rd_en_i is 0.
- R10: A write takes effect at the clock edge where wr_en_i is sampled, and the request outputs reflect it right after that edge.
- R11: req_vec_o[i] equals (pending[i] AND NOT mask[i]) OR force[i], and irq_o is 1 exactly when some bit of req_vec_o is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 64 | Raw interrupt source levels, possibly asynchronous |
| rd_en_i | input | 1 | Read strobe |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | 5 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the cycle of the read strobe |
| req_vec_o | output | 64 | Qualified request per source |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions assume that rd_en_i, wr_en_i, addr_i and wdata_i are synchronous to clk_i and stable around each rising edge. The source lines need no such assumption, because they pass through the synchronizer. The stimulus changes every input only at falling edges, and it holds each write strobe for exactly one rising edge. It also keeps reset low for several edges, so the synchronizer stages are clear before any assertion becomes active. Random phases send writes to read-only and unlisted offsets, and they change the sources freely. This exercises the ignore rule and the two-edge latency under the same input discipline.

// File: rtl/irqmf_pkg.sv
package irqmf_pkg;
    localparam int unsigned IRQMF_REG_W   = 32;
    localparam int unsigned IRQMF_HALVES  = 2;
    localparam int unsigned IRQMF_NUM_SRC = IRQMF_REG_W * IRQMF_HALVES;
    localparam int unsigned IRQMF_ADDR_W  = 5;
    localparam int unsigned IRQMF_SYNC_N  = 2;

    // Half index: 0 covers the low sources, 1 covers the high sources.
    localparam int unsigned HALF_LO = 0;
    localparam int unsigned HALF_HI = 1;

    typedef enum logic [IRQMF_ADDR_W-1:0] {
        OFF_PEND_HI  = 5'h00,
        OFF_PEND_LO  = 5'h04,
        OFF_MASK_HI  = 5'h08,
        OFF_MASK_LO  = 5'h0C,
        OFF_FORCE_HI = 5'h10,
        OFF_FORCE_LO = 5'h14
    } irqmf_off_e;
endpackage

// File: rtl/irqmf_sync.sv
module irqmf_sync #(
    parameter int unsigned WIDTH  = 64,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) stage_q[g] <= '0;
                else         stage_q[g] <= async_i;
            end
        end else begin : g_next
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) stage_q[g] <= '0;
                else         stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];

    if (STAGES > 1) begin : g_chk
        AST_SYNC_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
            sync_o == $past(stage_q[STAGES-2])); // R6
    end
endmodule

// File: rtl/irqmf_regs.sv
module irqmf_regs
    import irqmf_pkg::*;
#(
    parameter int unsigned REG_W = IRQMF_REG_W
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      rd_en_i,
    input  logic                      wr_en_i,
    input  logic [IRQMF_ADDR_W-1:0]   addr_i,
    input  logic [REG_W-1:0]          wdata_i,
    input  logic [2*REG_W-1:0]        pend_i,
    output logic [2*REG_W-1:0]        mask_o,
    output logic [2*REG_W-1:0]        force_o,
    output logic [REG_W-1:0]          rdata_o
);
    localparam int unsigned HALVES = 2;

    logic [REG_W-1:0]  mask_q  [HALVES];
    logic [REG_W-1:0]  force_q [HALVES];
    logic [HALVES-1:0] sel_mask;
    logic [HALVES-1:0] sel_force;

    // Write decode: pending and unlisted offsets select nothing.
    always_comb begin
        sel_mask  = '0;
        sel_force = '0;
        if (wr_en_i) begin
            unique case (addr_i)
                OFF_MASK_LO:  sel_mask[HALF_LO]  = 1'b1;
                OFF_MASK_HI:  sel_mask[HALF_HI]  = 1'b1;
                OFF_FORCE_LO: sel_force[HALF_LO] = 1'b1;
                OFF_FORCE_HI: sel_force[HALF_HI] = 1'b1;
                default: ;
            endcase
        end
    end

    for (genvar h = 0; h < HALVES; h++) begin : g_half
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)          mask_q[h] <= '1;
            else if (sel_mask[h]) mask_q[h] <= wdata_i;
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)           force_q[h] <= '0;
            else if (sel_force[h]) force_q[h] <= wdata_i;
        end

        assign mask_o[h*REG_W +: REG_W]  = mask_q[h];
        assign force_o[h*REG_W +: REG_W] = force_q[h];
    end

    // Read multiplexer, combinational on the strobe.
    always_comb begin
        rdata_o = '0;
        if (rd_en_i) begin
            unique case (addr_i)
                OFF_PEND_HI:  rdata_o = pend_i[HALF_HI*REG_W +: REG_W];
                OFF_PEND_LO:  rdata_o = pend_i[HALF_LO*REG_W +: REG_W];
                OFF_MASK_HI:  rdata_o = mask_q[HALF_HI];
                OFF_MASK_LO:  rdata_o = mask_q[HALF_LO];
                OFF_FORCE_HI: rdata_o = force_q[HALF_HI];
                OFF_FORCE_LO: rdata_o = force_q[HALF_LO];
                default:      rdata_o = '0;
            endcase
        end
    end

    AST_MASK_LO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && addr_i == OFF_MASK_LO) |=> mask_o[REG_W-1:0] == $past(wdata_i)); // R10
    AST_FORCE_HI_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && addr_i == OFF_FORCE_HI) |=> force_o[2*REG_W-1:REG_W] == $past(wdata_i)); // R4
    AST_RO_WRITE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && (addr_i == OFF_PEND_HI || addr_i == OFF_PEND_LO))
        |=> ($stable(mask_o) && $stable(force_o))); // R8
    AST_RDATA_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_en_i |-> rdata_o == '0); // R9
endmodule

// File: rtl/irqmf_qual.sv
module irqmf_qual #(
    parameter int unsigned NUM_SRC = 64
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] pend_i,
    input  logic [NUM_SRC-1:0] mask_i,
    input  logic [NUM_SRC-1:0] force_i,
    output logic [NUM_SRC-1:0] req_o,
    output logic               any_o
);
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        assign req_o[i] = (pend_i[i] & ~mask_i[i]) | force_i[i];
    end

    assign any_o = |req_o;

    AST_FORCE_ALWAYS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (force_i & ~req_o) == '0); // R4
    AST_MASK_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_o & mask_i & ~force_i) == '0); // R3
endmodule

// File: rtl/irqmf_top.sv
module irqmf_top
    import irqmf_pkg::*;
#(
    parameter int unsigned REG_W  = IRQMF_REG_W,
    parameter int unsigned SYNC_N = IRQMF_SYNC_N
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic [2*REG_W-1:0]      src_i,
    input  logic                    rd_en_i,
    input  logic                    wr_en_i,
    input  logic [IRQMF_ADDR_W-1:0] addr_i,
    input  logic [REG_W-1:0]        wdata_i,
    output logic [REG_W-1:0]        rdata_o,
    output logic [2*REG_W-1:0]      req_vec_o,
    output logic                    irq_o
);
    localparam int unsigned NUM_SRC = 2 * REG_W;

    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] mask;
    logic [NUM_SRC-1:0] frc;

    irqmf_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_N)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (src_i),
        .sync_o  (pend)
    );

    irqmf_regs #(.REG_W(REG_W)) u_regs (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .rd_en_i (rd_en_i),
        .wr_en_i (wr_en_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .pend_i  (pend),
        .mask_o  (mask),
        .force_o (frc),
        .rdata_o (rdata_o)
    );

    irqmf_qual #(.NUM_SRC(NUM_SRC)) u_qual (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .pend_i  (pend),
        .mask_i  (mask),
        .force_i (frc),
        .req_o   (req_vec_o),
        .any_o   (irq_o)
    );

    AST_IRQ_ANY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o == (req_vec_o != '0)); // R11
endmodule

// File: tb/tb_irqmf_top.sv
`timescale 1ns/1ps
module tb_irqmf_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [63:0] req_vec;
    logic        irq;

    int n_chk = 0;
    int n_err = 0;
    bit running = 1'b0;

    // Behavioural reference state
    logic [63:0] m_s1 = '0, m_s2 = '0, m_mask = '1, m_frc = '0;

    always #4 clk = ~clk; // 125 MHz

    irqmf_top dut (
        .clk_i(clk), .rst_ni(rst_n), .src_i(src), .rd_en_i(rd_en),
        .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
        .req_vec_o(req_vec), .irq_o(irq)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_mask = '1; m_frc = '0;
        end else begin
            m_s2 = m_s1;
            m_s1 = src;
            if (wr_en) begin
                case (addr)
                    5'h08: m_mask[63:32] = wdata;
                    5'h0C: m_mask[31:0]  = wdata;
                    5'h10: m_frc[63:32]  = wdata;
                    5'h14: m_frc[31:0]   = wdata;
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [63:0] m_req();
        return (m_s2 & ~m_mask) | m_frc;
    endfunction

    function automatic logic [31:0] m_read(input logic [4:0] a);
        case (a)
            5'h00: return m_s2[63:32];
            5'h04: return m_s2[31:0];
            5'h08: return m_mask[63:32];
            5'h0C: return m_mask[31:0];
            5'h10: return m_frc[63:32];
            5'h14: return m_frc[31:0];
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Every-cycle comparison of the request outputs (R11)
    always @(negedge clk) begin
        if (running && rst_n) begin
            chk("R11 req_vec", req_vec, m_req());
            chk("R11 irq", {63'b0, irq}, {63'b0, |m_req()});
        end
    end

    task automatic do_wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_rd(input string tag, input logic [4:0] a, input logic [31:0] exp);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1;
        chk(tag, {32'b0, rdata}, {32'b0, exp});
        #2;
        rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        running = 1'b1;

        // R1: reset state
        do_rd("R1 mask lo", 5'h0C, 32'hFFFF_FFFF);
        do_rd("R1 mask hi", 5'h08, 32'hFFFF_FFFF);
        do_rd("R1 force lo", 5'h14, 32'h0);
        do_rd("R1 force hi", 5'h10, 32'h0);
        chk("R1 irq", {63'b0, irq}, 64'h0);

        // R5, R2, R3: masked sources still visible in pending, no request
        @(negedge clk); src = 64'hA5A5_0000_0000_0F0F;
        idle(3);
        do_rd("R5 R2 pend lo", 5'h04, 32'h0000_0F0F);
        do_rd("R5 R2 pend hi", 5'h00, 32'hA5A5_0000);
        chk("R3 masked irq", {63'b0, irq}, 64'h0);

        // R6: two-edge latency on bit 4
        @(negedge clk); src[4] = 1'b1;
        do_rd("R6 one edge", 5'h04, 32'h0000_0F0F);
        do_rd("R6 two edges", 5'h04, 32'h0000_0F1F);

        // R3, R10: unmask bits 0..3
        do_wr(5'h0C, 32'hFFFF_FFF0);
        chk("R10 R3 req after write", req_vec, 64'h0000_0000_0000_000F);
        chk("R3 irq unmasked", {63'b0, irq}, 64'h1);

        // R4, R2: force source 32 while its source is low and it is masked
        do_wr(5'h10, 32'h0000_0001);
        chk("R4 R2 forced source 32", {63'b0, req_vec[32]}, 64'h1);
        do_wr(5'h10, 32'h0);
        chk("R4 force removed", {63'b0, req_vec[32]}, 64'h0);

        // R8: writes to read-only and unlisted offsets
        do_wr(5'h00, 32'h1234_5678);
        do_wr(5'h04, 32'h0);
        do_wr(5'h18, 32'h0);
        do_wr(5'h1C, 32'hFFFF_FFFF);
        do_rd("R8 mask lo kept", 5'h0C, 32'hFFFF_FFF0);
        do_rd("R8 mask hi kept", 5'h08, 32'hFFFF_FFFF);
        do_rd("R8 force lo kept", 5'h14, 32'h0);
        do_rd("R8 force hi kept", 5'h10, 32'h0);

        // R9, R7: unlisted read and no strobe
        do_rd("R9 unlisted read", 5'h18, 32'h0);
        @(negedge clk); addr = 5'h0C; #1;
        chk("R9 no strobe", {32'b0, rdata}, 64'h0);

        // R2: high side unmask
        do_wr(5'h08, 32'h0000_FFFF);
        do_wr(5'h08, 32'hFFFE_FFFF);
        chk("R2 source 48 request", {63'b0, req_vec[48]}, 64'h1);

        // R5: pending does not latch
        @(negedge clk); src = '0;
        idle(2);
        do_rd("R5 pend lo cleared", 5'h04, 32'h0);
        do_rd("R5 pend hi cleared", 5'h00, 32'h0);
        chk("R5 irq clear", {63'b0, irq}, 64'h0);

        // Random phase, every-cycle model comparison (R7, R8, R11)
        for (int n = 0; n < 400; n++) begin
            @(negedge clk);
            rd_en = 1'b0; wr_en = 1'b0;
            src = {$urandom, $urandom};
            case ($urandom_range(0, 2))
                0: begin
                    wr_en = 1'b1;
                    addr = 5'(4 * $urandom_range(0, 7));
                    wdata = $urandom;
                end
                1: begin
                    rd_en = 1'b1;
                    addr = 5'(4 * $urandom_range(0, 7));
                    #1;
                    chk("R7 random read", {32'b0, rdata}, {32'b0, m_read(addr)});
                end
                default: ;
            endcase
        end
        @(negedge clk); rd_en = 1'b0; wr_en = 1'b0;
        idle(2);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule